// File: doc/BRIEF.md
# Dual-Side Inter-Processor Mailbox

This block joins two processors, side A and side B, that run on one shared clock. Each side has its own simple register port. Each side has four 32-bit outgoing message slots. A word written into outgoing slot n becomes the word in the peer's incoming slot n. Per-slot empty and full bits let both ends see when a slot can be reused.

Each side also publishes a 3-bit flag value to the peer. The value reaches the peer after a fixed two-cycle delay, and new writes are locked out while it is in transit. Each side can also post four doorbell requests to the peer. A doorbell stays pending until the peer acknowledges it, and the poster can read it back in the meantime. Every status source has an enable bit, and the enabled sources OR together into one interrupt line per side.

A register access takes one cycle on `*_valid`. Read data is combinational from the address. Side effects, such as a read emptying a slot, take place at the clock edge that ends the access.

Top module: `ipc_mailbox`

## Requirements
- R1: A write of word D to address n (0..3) on one side makes a read of address n on the other side return D from the next cycle on.
- R2: In status (address 4), the outgoing-empty field is at bits 23:20 and the incoming-full field at bits 27:24. A slot write clears the writer's empty bit and sets the peer's full bit from the next cycle. A read of incoming slot n clears that full bit and sets the peer's empty bit from the next cycle.
- R3: Within every 4-bit per-slot field of status and control, slot n occupies field base + (3 - n), so slot 0 is the highest bit.
- R4: Address 6 returns the peer's published flags in bits 2:0 and the side's own flags in bits 10:8. Writing a new value to bits 2:0 raises status bit 8 for exactly two cycles, and the peer's copy takes the new value when bit 8 falls.
- R5: A flag write is ignored while status bit 8 is set. A write of the value already held does not raise bit 8.
- R6: Writing 1 to control bit 16 + (3 - n) (address 5) raises doorbell n. The peer's status pending field (bits 31:28) shows it, and the requester reads it back in the same control bits.
- R7: A doorbell stays pending until the peer writes 1 to its status pending bit, which clears the request on both sides. Writing 0 to a request bit, or raising one that is already pending, has no effect.
- R8: Status bit 4 is set exactly when any incoming-full or doorbell-pending bit of that side is set.
- R9: Control bits 23:20, 27:24 and 31:28 enable outgoing-empty, incoming-full and doorbell-pending sources. A control write replaces them all. The side's irq is the OR of each status bit ANDed with its enable.
- R10: After reset, all outgoing slots are empty, no full or pending bits are set, flags and enables are zero, and irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rst | input | 1 | Synchronous active-high reset |
| a_valid | input | 1 | Side A access strobe |
| a_write | input | 1 | Side A write (1) or read (0) |
| a_addr | input | 3 | Side A word address |
| a_wdata | input | 32 | Side A write data |
| a_rdata | output | 32 | Side A read data |
| a_irq | output | 1 | Side A interrupt |
| b_valid | input | 1 | Side B access strobe |
| b_write | input | 1 | Side B write (1) or read (0) |
| b_addr | input | 3 | Side B word address |
| b_wdata | input | 32 | Side B write data |
| b_rdata | output | 32 | Side B read data |
| b_irq | output | 1 | Side B interrupt |

## Verification
A slot's full bit that is wrong appears on both sides at once. It shows in the sender's empty field, the receiver's full field and event bit, and in any enabled irq, all within one cycle. Because of that, the per-cycle irq comparison and the status reads catch it immediately. A wrong flag counter shows up as a flags-updating bit that is high for the wrong number of cycles, or as a peer copy that changes early. The reads are placed on each of the two transit cycles so that such a fault is seen. A doorbell that clears too early, or latches twice, is seen on the next readback of the requester's control word.

// File: rtl/ipc_mb_pkg.sv
package ipc_mb_pkg;

    localparam int NCH = 4;
    localparam int DW  = 32;
    localparam int FW  = 3;
    localparam int AW  = 3;

    localparam int GPR_LSB  = 16;
    localparam int TXE_LSB  = 20;
    localparam int RXF_LSB  = 24;
    localparam int GPP_LSB  = 28;
    localparam int EVT_BIT  = 4;
    localparam int FUP_BIT  = 8;
    localparam int OWNF_LSB = 8;

    typedef enum logic [AW-1:0] {
        ADR_SLOT0 = 3'd0,
        ADR_SLOT1 = 3'd1,
        ADR_SLOT2 = 3'd2,
        ADR_SLOT3 = 3'd3,
        ADR_STAT  = 3'd4,
        ADR_CTRL  = 3'd5,
        ADR_FLAG  = 3'd6,
        ADR_NONE  = 3'd7
    } reg_adr_e;

    typedef struct packed {
        logic          valid;
        logic          write;
        reg_adr_e      addr;
        logic [DW-1:0] wdata;
    } bus_req_t;

    typedef struct packed {
        logic [NCH-1:0] txe;
        logic [NCH-1:0] rxf;
        logic [NCH-1:0] gp;
    } en_set_t;

    function automatic logic [NCH-1:0] swap_order(input logic [NCH-1:0] v);
        logic [NCH-1:0] r;
        for (int i = 0; i < NCH; i++) r[NCH-1-i] = v[i];
        return r;
    endfunction

    function automatic logic [DW-1:0] put_field(input logic [NCH-1:0] chans, input int lsb);
        return DW'(swap_order(chans)) << lsb;
    endfunction

    function automatic logic [NCH-1:0] get_field(input logic [DW-1:0] w, input int lsb);
        return swap_order(w[lsb +: NCH]);
    endfunction

endpackage

// File: rtl/ipc_mb_msg_path.sv
module ipc_mb_msg_path import ipc_mb_pkg::*; (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NCH-1:0]           wr,
    input  logic [DW-1:0]            wdata,
    input  logic [NCH-1:0]           rd,
    output logic [NCH-1:0][DW-1:0]   data,
    output logic [NCH-1:0]           full
);

    for (genvar g = 0; g < NCH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                data[g] <= '0;
                full[g] <= 1'b0;
            end else if (wr[g]) begin
                data[g] <= wdata;
                full[g] <= 1'b1;
            end else if (rd[g]) begin
                full[g] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/ipc_mb_flag_path.sv
module ipc_mb_flag_path import ipc_mb_pkg::*; #(
    parameter int LAT = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr,
    input  logic [FW-1:0] wval,
    output logic [FW-1:0] own,
    output logic [FW-1:0] copy,
    output logic          busy
);

    localparam int CW = $clog2(LAT + 1);

    logic [CW-1:0] cnt;

    assign busy = (cnt != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            own  <= '0;
            copy <= '0;
        end else if (busy) begin
            cnt <= cnt - CW'(1);
            if (cnt == CW'(1)) copy <= own;
        end else if (wr && (wval != own)) begin
            own <= wval;
            cnt <= CW'(LAT);
        end
    end

endmodule

// File: rtl/ipc_mb_gp_path.sv
module ipc_mb_gp_path import ipc_mb_pkg::*; (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] raise,
    input  logic [NCH-1:0] ack,
    output logic [NCH-1:0] pend
);

    always_ff @(posedge clk) begin
        if (rst) pend <= '0;
        else     pend <= (pend & ~ack) | (raise & ~pend);
    end

endmodule

// File: rtl/ipc_mb_side.sv
module ipc_mb_side import ipc_mb_pkg::*; (
    input  logic                   clk,
    input  logic                   rst,
    input  bus_req_t               req,
    input  logic [NCH-1:0]         tx_full,
    input  logic [NCH-1:0]         rx_full,
    input  logic [NCH-1:0][DW-1:0] rx_data,
    input  logic                   flag_busy,
    input  logic [FW-1:0]          own_flags,
    input  logic [FW-1:0]          peer_flags,
    input  logic [NCH-1:0]         gp_out_pend,
    input  logic [NCH-1:0]         gp_in_pend,
    output logic [NCH-1:0]         tx_wr,
    output logic [NCH-1:0]         rx_rd,
    output logic [DW-1:0]          tx_wdata,
    output logic                   flag_wr,
    output logic [NCH-1:0]         gp_raise,
    output logic [NCH-1:0]         gp_ack,
    output logic [DW-1:0]          rdata,
    output logic                   irq
);

    localparam int IW = $clog2(NCH);

    logic [AW-1:0]  adr;
    logic           is_chan, wr_op, rd_op, stat_wr, ctrl_wr, evt;
    logic [NCH-1:0] chan_sel, tx_empty;
    en_set_t        en_q;

    assign adr      = req.addr;
    assign is_chan  = (adr < AW'(NCH));
    assign wr_op    = req.valid && req.write;
    assign rd_op    = req.valid && !req.write;
    assign stat_wr  = wr_op && (req.addr == ADR_STAT);
    assign ctrl_wr  = wr_op && (req.addr == ADR_CTRL);
    assign tx_empty = ~tx_full;
    assign evt      = (rx_full != '0) || (gp_in_pend != '0);

    always_comb begin
        chan_sel = '0;
        if (is_chan) chan_sel[adr[IW-1:0]] = 1'b1;
    end

    assign tx_wr    = wr_op ? chan_sel : '0;
    assign rx_rd    = rd_op ? chan_sel : '0;
    assign tx_wdata = req.wdata;
    assign flag_wr  = wr_op && (req.addr == ADR_FLAG);
    assign gp_ack   = stat_wr ? get_field(req.wdata, GPP_LSB) : '0;
    assign gp_raise = ctrl_wr ? get_field(req.wdata, GPR_LSB) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
        end else if (ctrl_wr) begin
            en_q.txe <= get_field(req.wdata, TXE_LSB);
            en_q.rxf <= get_field(req.wdata, RXF_LSB);
            en_q.gp  <= get_field(req.wdata, GPP_LSB);
        end
    end

    assign irq = ((tx_empty & en_q.txe) != '0) ||
                 ((rx_full & en_q.rxf) != '0) ||
                 ((gp_in_pend & en_q.gp) != '0);

    always_comb begin
        rdata = '0;
        if (is_chan) begin
            rdata = rx_data[adr[IW-1:0]];
        end else begin
            case (req.addr)
                ADR_STAT: rdata = put_field(tx_empty, TXE_LSB)
                                | put_field(rx_full, RXF_LSB)
                                | put_field(gp_in_pend, GPP_LSB)
                                | (DW'(evt) << EVT_BIT)
                                | (DW'(flag_busy) << FUP_BIT);
                ADR_CTRL: rdata = put_field(en_q.txe, TXE_LSB)
                                | put_field(en_q.rxf, RXF_LSB)
                                | put_field(en_q.gp, GPP_LSB)
                                | put_field(gp_out_pend, GPR_LSB);
                ADR_FLAG: rdata = DW'(peer_flags) | (DW'(own_flags) << OWNF_LSB);
                default:  rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox import ipc_mb_pkg::*; #(
    parameter int FLAG_LAT = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          a_valid,
    input  logic          a_write,
    input  logic [AW-1:0] a_addr,
    input  logic [DW-1:0] a_wdata,
    output logic [DW-1:0] a_rdata,
    output logic          a_irq,
    input  logic          b_valid,
    input  logic          b_write,
    input  logic [AW-1:0] b_addr,
    input  logic [DW-1:0] b_wdata,
    output logic [DW-1:0] b_rdata,
    output logic          b_irq
);

    localparam int NSIDE = 2;

    bus_req_t [NSIDE-1:0]                 req;
    logic     [NSIDE-1:0][DW-1:0]         rdata_s, tx_wdata;
    logic     [NSIDE-1:0]                 irq_s, flag_wr, flag_busy;
    logic     [NSIDE-1:0][NCH-1:0]        tx_wr, rx_rd, msg_full, gp_raise, gp_ack, gp_pend;
    logic     [NSIDE-1:0][NCH-1:0][DW-1:0] msg_data;
    logic     [NSIDE-1:0][FW-1:0]         flag_own, flag_copy;

    always_comb begin
        req[0] = '{valid: a_valid, write: a_write, addr: reg_adr_e'(a_addr), wdata: a_wdata};
        req[1] = '{valid: b_valid, write: b_write, addr: reg_adr_e'(b_addr), wdata: b_wdata};
    end

    for (genvar g = 0; g < NSIDE; g++) begin : g_side
        ipc_mb_msg_path u_msg (
            .clk   (clk),
            .rst   (rst),
            .wr    (tx_wr[g]),
            .wdata (tx_wdata[g]),
            .rd    (rx_rd[1-g]),
            .data  (msg_data[g]),
            .full  (msg_full[g])
        );

        ipc_mb_flag_path #(.LAT(FLAG_LAT)) u_flag (
            .clk  (clk),
            .rst  (rst),
            .wr   (flag_wr[g]),
            .wval (tx_wdata[g][FW-1:0]),
            .own  (flag_own[g]),
            .copy (flag_copy[g]),
            .busy (flag_busy[g])
        );

        ipc_mb_gp_path u_gp (
            .clk   (clk),
            .rst   (rst),
            .raise (gp_raise[g]),
            .ack   (gp_ack[1-g]),
            .pend  (gp_pend[g])
        );

        ipc_mb_side u_regs (
            .clk         (clk),
            .rst         (rst),
            .req         (req[g]),
            .tx_full     (msg_full[g]),
            .rx_full     (msg_full[1-g]),
            .rx_data     (msg_data[1-g]),
            .flag_busy   (flag_busy[g]),
            .own_flags   (flag_own[g]),
            .peer_flags  (flag_copy[1-g]),
            .gp_out_pend (gp_pend[g]),
            .gp_in_pend  (gp_pend[1-g]),
            .tx_wr       (tx_wr[g]),
            .rx_rd       (rx_rd[g]),
            .tx_wdata    (tx_wdata[g]),
            .flag_wr     (flag_wr[g]),
            .gp_raise    (gp_raise[g]),
            .gp_ack      (gp_ack[g]),
            .rdata       (rdata_s[g]),
            .irq         (irq_s[g])
        );
    end

    assign a_rdata = rdata_s[0];
    assign b_rdata = rdata_s[1];
    assign a_irq   = irq_s[0];
    assign b_irq   = irq_s[1];

endmodule

// File: rtl/ipc_mb_chk.sv
module ipc_mb_chk import ipc_mb_pkg::*; (
    input logic                clk,
    input logic                rst,
    input logic                a_valid,
    input logic                a_write,
    input logic [AW-1:0]       a_addr,
    input logic                b_valid,
    input logic                b_write,
    input logic [AW-1:0]       b_addr,
    input logic [1:0][NCH-1:0] msg_full,
    input logic [1:0]          flag_busy,
    input logic [1:0][FW-1:0]  flag_copy,
    input logic [1:0][NCH-1:0] gp_pend,
    input logic [1:0][NCH-1:0] gp_raise,
    input logic [1:0][NCH-1:0] gp_ack
);

    // R2
    slot_write_fills_chk: assert property (@(posedge clk) disable iff (rst)
        (a_valid && a_write && a_addr == 3'd0) |=> msg_full[0][0]);

    // R2
    slot_full_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (msg_full[0][0] && !(b_valid && !b_write && b_addr == 3'd0)) |=> msg_full[0][0]);

    // R2
    slot_read_drains_chk: assert property (@(posedge clk) disable iff (rst)
        (b_valid && !b_write && b_addr == 3'd0 && !(a_valid && a_write && a_addr == 3'd0))
        |=> !msg_full[0][0]);

    // R4
    flag_busy_two_cycles_chk: assert property (@(posedge clk) disable iff (rst)
        (flag_busy[0] && $past(flag_busy[0])) |=> !flag_busy[0]);

    // R4
    flag_copy_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(flag_copy[0]) |-> $past(flag_busy[0]));

    // R7
    bell_rise_needs_raise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(gp_pend[0][0]) |-> $past(gp_raise[0][0]));

    // R7
    bell_holds_until_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (gp_pend[0][2] && !gp_ack[1][2]) |=> gp_pend[0][2]);

endmodule

bind ipc_mailbox ipc_mb_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .a_valid   (a_valid),
    .a_write   (a_write),
    .a_addr    (a_addr),
    .b_valid   (b_valid),
    .b_write   (b_write),
    .b_addr    (b_addr),
    .msg_full  (msg_full),
    .flag_busy (flag_busy),
    .flag_copy (flag_copy),
    .gp_pend   (gp_pend),
    .gp_raise  (gp_raise),
    .gp_ack    (gp_ack)
);

// File: tb/ipc_mailbox_tb.sv
module ipc_mailbox_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        a_valid = 1'b0, a_write = 1'b0, b_valid = 1'b0, b_write = 1'b0;
    logic [2:0]  a_addr = '0, b_addr = '0;
    logic [31:0] a_wdata = '0, b_wdata = '0;
    logic [31:0] a_rdata, b_rdata;
    logic        a_irq, b_irq;

    always #4 clk = ~clk;

    ipc_mailbox u_dut (
        .clk(clk), .rst(rst),
        .a_valid(a_valid), .a_write(a_write), .a_addr(a_addr), .a_wdata(a_wdata),
        .a_rdata(a_rdata), .a_irq(a_irq),
        .b_valid(b_valid), .b_write(b_write), .b_addr(b_addr), .b_wdata(b_wdata),
        .b_rdata(b_rdata), .b_irq(b_irq)
    );

    int n_run = 0;
    int n_fail = 0;
    bit live = 1'b0;

    // reference model; index = side that owns / sent it
    logic [3:0]  m_full [2];
    logic [31:0] m_data [2][4];
    logic [2:0]  m_own  [2];
    logic [2:0]  m_copy [2];
    int          m_cnt  [2];
    logic [3:0]  m_pend [2];
    logic [3:0]  m_etx  [2];
    logic [3:0]  m_erx  [2];
    logic [3:0]  m_egp  [2];

    function automatic logic [31:0] fld(logic [3:0] c, int lsb);
        logic [31:0] r = '0;
        for (int n = 0; n < 4; n++) r[lsb + 3 - n] = c[n];
        return r;
    endfunction

    function automatic logic [3:0] unf(logic [31:0] w, int lsb);
        logic [3:0] r;
        for (int n = 0; n < 4; n++) r[n] = w[lsb + 3 - n];
        return r;
    endfunction

    function automatic logic [31:0] exp_rd(int s, int a);
        int p = 1 - s;
        logic [31:0] r = '0;
        if (a < 4) return m_data[p][a];
        case (a)
            4: begin
                r = fld(~m_full[s], 20) | fld(m_full[p], 24) | fld(m_pend[p], 28);
                r[4] = (m_full[p] != 0) || (m_pend[p] != 0);
                r[8] = (m_cnt[s] != 0);
            end
            5: r = fld(m_etx[s], 20) | fld(m_erx[s], 24) | fld(m_egp[s], 28) | fld(m_pend[s], 16);
            6: begin
                r[2:0]  = m_copy[p];
                r[10:8] = m_own[s];
            end
            default: r = '0;
        endcase
        return r;
    endfunction

    function automatic logic exp_irq(int s);
        int p = 1 - s;
        return ((~m_full[s] & m_etx[s]) != 0) || ((m_full[p] & m_erx[s]) != 0) ||
               ((m_pend[p] & m_egp[s]) != 0);
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic m_reset();
        for (int k = 0; k < 2; k++) begin
            m_full[k] = '0; m_own[k] = '0; m_copy[k] = '0; m_cnt[k] = 0;
            m_pend[k] = '0; m_etx[k] = '0; m_erx[k] = '0; m_egp[k] = '0;
            for (int n = 0; n < 4; n++) m_data[k][n] = '0;
        end
    endtask

    // one clock edge of the model; s < 0 means no access
    task automatic step(int s, bit w, int a, logic [31:0] d);
        int oldc = (s >= 0) ? m_cnt[s] : 0;
        int p = 1 - s;
        for (int k = 0; k < 2; k++) begin
            if (m_cnt[k] != 0) begin
                if (m_cnt[k] == 1) m_copy[k] = m_own[k];
                m_cnt[k]--;
            end
        end
        if (s < 0) return;
        if (a < 4) begin
            if (w) begin m_data[s][a] = d; m_full[s][a] = 1'b1; end
            else m_full[p][a] = 1'b0;
        end else if (w) begin
            case (a)
                4: m_pend[p] = m_pend[p] & ~unf(d, 28);
                5: begin
                    m_etx[s] = unf(d, 20);
                    m_erx[s] = unf(d, 24);
                    m_egp[s] = unf(d, 28);
                    m_pend[s] = m_pend[s] | unf(d, 16);
                end
                6: if (oldc == 0 && d[2:0] != m_own[s]) begin
                    m_own[s] = d[2:0];
                    m_cnt[s] = 2;
                end
                default: ;
            endcase
        end
    endtask

    task automatic op(int s, bit w, int a, logic [31:0] d, string tag);
        @(negedge clk);
        a_valid = (s == 0); a_write = w; a_addr = 3'(a); a_wdata = d;
        b_valid = (s == 1); b_write = w; b_addr = 3'(a); b_wdata = d;
        #1;
        if (!w) check(tag, (s == 0) ? a_rdata : b_rdata, exp_rd(s, a));
        @(posedge clk);
        step(s, w, a, d);
    endtask

    task automatic idle(int cycles);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            a_valid = 1'b0; b_valid = 1'b0;
            @(posedge clk);
            step(-1, 1'b0, 0, '0);
        end
    endtask

    // R9: irq compared with the model every cycle
    always @(negedge clk) begin
        if (live) begin
            check("R9 a_irq", {31'b0, a_irq}, {31'b0, exp_irq(0)});
            check("R9 b_irq", {31'b0, b_irq}, {31'b0, exp_irq(1)});
        end
    end

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        m_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        live = 1'b1;

        // R10 reset state
        op(0, 0, 4, '0, "R10 status A");
        check("R10 status A literal", a_rdata, 32'h00F0_0000);
        op(1, 0, 5, '0, "R10 control B");
        op(0, 0, 6, '0, "R10 flags A");
        op(1, 0, 4, '0, "R10 status B");

        // R1 R2 R3 A to B
        op(0, 1, 1, 32'hDEAD_BEEF, "R1 A write slot1");
        op(1, 0, 4, '0, "R2 B status full1");
        op(0, 0, 4, '0, "R3 A status empty field");
        op(1, 0, 1, '0, "R1 B read slot1");
        op(1, 0, 4, '0, "R2 B full cleared");
        op(0, 0, 4, '0, "R2 A empty restored");
        // B to A on two slots
        op(1, 1, 3, 32'h1234_5678, "R1 B write slot3");
        op(1, 1, 0, 32'hA5A5_0001, "R1 B write slot0");
        op(0, 0, 4, '0, "R3 A status two full");
        op(1, 0, 4, '0, "R3 B status two empty cleared");
        op(0, 0, 3, '0, "R1 A read slot3");
        op(0, 0, 0, '0, "R1 A read slot0");
        op(0, 0, 4, '0, "R8 A event clear");

        // R4 flag propagation timing
        op(0, 1, 6, 32'd5, "R4 A flag write");
        op(0, 0, 4, '0, "R4 busy cycle1");
        op(1, 0, 6, '0, "R4 peer copy old");
        op(0, 0, 4, '0, "R4 busy fallen");
        op(1, 0, 6, '0, "R4 peer copy new");

        // R5 lockout and same-value write
        op(1, 1, 6, 32'd3, "R5 B flag write");
        op(1, 1, 6, 32'd6, "R5 B write while busy");
        idle(3);
        op(0, 0, 6, '0, "R5 A sees 3");
        op(1, 0, 6, '0, "R5 B own 3");
        op(1, 1, 6, 32'd3, "R5 same value");
        op(1, 0, 4, '0, "R5 no busy");

        // R6 R7 doorbells
        op(0, 1, 5, 32'h0002_0000, "R6 A raise bell2");
        op(1, 0, 4, '0, "R6 B status pending2");
        op(0, 0, 5, '0, "R6 A readback");
        op(0, 1, 5, 32'h000A_0000, "R7 re-raise bell2 plus bell0");
        op(0, 0, 5, '0, "R7 readback two");
        op(1, 1, 4, 32'h2000_0000, "R7 B ack bell2");
        op(0, 0, 5, '0, "R7 bell2 cleared");
        op(1, 0, 4, '0, "R7 B status bell0 only");
        op(0, 1, 5, 32'h0000_0000, "R7 zero write");
        op(0, 0, 5, '0, "R7 bell0 still pending");
        op(1, 1, 4, 32'h8000_0000, "R7 B ack bell0");
        op(1, 0, 4, '0, "R8 B event clear");

        // R9 enables
        op(1, 1, 5, 32'h0400_0000, "R9 B full1 enable");
        op(0, 1, 1, 32'h0000_0077, "R9 A write slot1");
        op(1, 0, 1, '0, "R9 B read slot1");
        op(0, 1, 5, 32'h00F0_0000, "R9 A empty enables");
        op(1, 1, 5, 32'h8000_0000, "R9 B bell0 enable");
        op(0, 1, 5, 32'h00F8_0000, "R9 A raise bell0");
        op(1, 0, 4, '0, "R9 B status bell0");
        op(1, 1, 4, 32'h8000_0000, "R9 B ack bell0");
        for (int n = 0; n < 4; n++) op(0, 1, n, 32'h100 + n, "R9 A fill slots");
        op(0, 0, 4, '0, "R2 A all full");
        for (int n = 0; n < 4; n++) op(1, 0, n, '0, "R1 B drain slots");
        op(0, 0, 4, '0, "R2 A all empty");
        idle(2);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule